// File: doc/BRIEF.md
# Converter Bus Handshake and Completion Interrupt

This block is the processor-side control of an 8-bit successive-approximation converter. Three active-low strobes arrive from the bus: chip select, write and read. They are brought into the local clock through a two-stage synchronizer. Holding chip select and write low together is a start request. While that request lasts, the block keeps the conversion sequencer in reset. When either strobe goes high again, the block sends the sequencer a single-cycle start pulse. A start request also drives the completion interrupt inactive.

The sequencer itself is outside this block. It reports a finished result as a one-cycle `conv_done` pulse carrying `conv_code`. That pulse is a valid strobe with no ready: the converter cannot stall, so there is no back-pressure. The block accepts a result only while a conversion it launched is still running. An accepted result is copied into the output latch, and the interrupt goes low one clock after the copy.

A read (chip select and read low together) clears the interrupt and places the latched word on the data bus. The three-state data pins are modelled as a data value plus an enable flag. Tying the interrupt output back to the write strobe, with chip select held low, makes the converter start again after every result. That loop needs one external write pulse after power-up to begin.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: After reset the block drives `intr_n`=1, `dout_oe`=0, `dout`=0, `seq_reset`=0 and `seq_start`=0.
- R2: Each strobe passes through two synchronizer flops. With `cs_n` and `wr_n` both low, `seq_reset` is 1 from the third rising edge after the inputs fall. It stays 1 for as long as both remain low, however long that is.
- R3: A start request forces `intr_n` to 1 in the same cycle that `seq_reset` becomes 1. `intr_n` stays 1 for as long as `seq_reset` is 1.
- R4: When either strobe returns high, `seq_reset` returns to 0 on the third rising edge. In that same cycle `seq_start` is 1, and only for that one cycle.
- R5: Take a `conv_done` pulse sampled on an edge while a launched conversion is running. The output latch captures `conv_code` on that edge, and `intr_n` goes to 0 one edge later.
- R6: With `cs_n` and `rd_n` both low, after two synchronizer edges `dout_oe`=1 and `dout` equals the latched word. `intr_n` returns to 1 one edge after that. Whenever no read is active, `dout_oe`=0 and `dout`=0.
- R7: Suppose a new start request arrives during a conversion. A `conv_done` that arrives while the restart is held is then ignored: the latch keeps the previous result and `intr_n` stays 1.
- R8: A `conv_done` that arrives when no conversion is running changes neither the latch nor `intr_n`.
- R9: With `cs_n` held low and `wr_n` driven from `intr_n`, one external write pulse after start-up leads to repeated conversions. Each one produces its own start pulse and its own interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| wr_n | input | 1 | Write (start) strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| conv_done | input | 1 | One-cycle result-valid pulse from the sequencer |
| conv_code | input | 8 | Result word, qualified by conv_done |
| seq_reset | output | 1 | Holds the sequencer in reset |
| seq_start | output | 1 | One-cycle launch pulse to the sequencer |
| intr_n | output | 1 | Completion interrupt, active low |
| dout | output | 8 | Data bus value, zero when not enabled |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
The main start, complete and read path runs once for each of the 256 result codes. This shows whether the latch carries every bit pattern to the bus. In each pass the strobe-hold width is varied from one to four cycles, which separates holding on a persistent request from starting on the request's leading edge. Further sequences place a result while the block is idle, and a result while a restart is held. These show whether the block accepts a result only for the conversion it launched. A closed loop from the interrupt to the write strobe then checks that the block restarts itself repeatedly once it is kicked.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int CODE_W_DEF   = 8;
  localparam int SYNC_DEF     = 2;
  localparam int CTRL_N       = 3;
  // Bit positions of the strobes inside the synchronized control vector
  localparam int IDX_CS = 2;
  localparam int IDX_WR = 1;
  localparam int IDX_RD = 0;
endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cvt_start_ctl.sv
module cvt_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic xfer,
  output logic hold,
  output logic launch,
  output logic busy
);
  logic release_now;

  // The request has gone away while the hold flop still reflects it
  assign release_now = hold & ~start_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold   <= 1'b0;
      launch <= 1'b0;
      busy   <= 1'b0;
    end else begin
      hold   <= start_req;
      launch <= release_now;
      if (start_req)        busy <= 1'b0;
      else if (release_now) busy <= 1'b1;
      else if (xfer)        busy <= 1'b0;
    end
endmodule

// File: rtl/cvt_result.sv
module cvt_result #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              busy,
  input  logic              start_req,
  input  logic              rd_req,
  output logic              xfer,
  output logic [CODE_W-1:0] word_q,
  output logic              intr_n,
  output logic [CODE_W-1:0] dout,
  output logic              dout_oe
);
  logic xfer_d;
  logic flag;

  // A result counts only for a launched run that no restart has overtaken
  assign xfer = conv_done & busy & ~start_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_q <= '0;
      xfer_d <= 1'b0;
      flag   <= 1'b0;
    end else begin
      xfer_d <= xfer;
      if (xfer) word_q <= conv_code;
      if (start_req)   flag <= 1'b0;
      else if (xfer_d) flag <= 1'b1;
      else if (rd_req) flag <= 1'b0;
    end

  assign intr_n  = ~flag;
  assign dout_oe = rd_req;
  assign dout    = rd_req ? word_q : '0;
endmodule

// File: rtl/cvt_bus_ctrl.sv
module cvt_bus_ctrl
  import cvt_pkg::*;
#(
  parameter int CODE_W      = CODE_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic              seq_reset,
  output logic              seq_start,
  output logic              intr_n,
  output logic [CODE_W-1:0] dout,
  output logic              dout_oe
);
  logic [CTRL_N-1:0] ctl_s;
  logic              start_req;
  logic              rd_req;
  logic              busy;
  logic              xfer;
  logic [CODE_W-1:0] res_word;

  cvt_sync #(.W(CTRL_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, wr_n, rd_n}),
    .q     (ctl_s)
  );

  assign start_req = ~ctl_s[IDX_CS] & ~ctl_s[IDX_WR];
  assign rd_req    = ~ctl_s[IDX_CS] & ~ctl_s[IDX_RD];

  cvt_start_ctl u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .xfer      (xfer),
    .hold      (seq_reset),
    .launch    (seq_start),
    .busy      (busy)
  );

  cvt_result #(.CODE_W(CODE_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_code (conv_code),
    .busy      (busy),
    .start_req (start_req),
    .rd_req    (rd_req),
    .xfer      (xfer),
    .word_q    (res_word),
    .intr_n    (intr_n),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );
endmodule

// File: rtl/cvt_bus_ctrl_chk.sv
module cvt_bus_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic              seq_reset,
  input logic              seq_start,
  input logic              intr_n,
  input logic [CODE_W-1:0] dout,
  input logic              dout_oe,
  input logic [CODE_W-1:0] res_word
);
  // R3: interrupt inactive while the sequencer is held
  a_r3_intr_high_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reset |-> intr_n);

  // R4: launch never overlaps the hold
  a_r4_start_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !seq_reset);

  // R4: launch lasts a single cycle
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

  // R5: interrupt only falls two edges after a result strobe
  a_r5_intr_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> $past(conv_done, 2));

  // R6: bus is quiet when not enabled
  a_r6_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  // R7: the latch moves only after a result strobe
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(res_word));
endmodule

bind cvt_bus_ctrl cvt_bus_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_done (conv_done),
  .seq_reset (seq_reset),
  .seq_start (seq_start),
  .intr_n    (intr_n),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .res_word  (res_word)
);

// File: tb/sim_cvt_bus_ctrl.sv
`timescale 1ns/1ps
module sim_cvt_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1;
  logic       man_done = 1'b0;
  logic [7:0] man_code = '0;
  logic       fr_mode = 1'b0, kick = 1'b0;
  logic       fr_done = 1'b0;
  logic [7:0] fr_code = '0;
  int         fr_cnt = 0;
  logic       wr_n, conv_done;
  logic [7:0] conv_code;
  logic       seq_reset, seq_start, intr_n, dout_oe;
  logic [7:0] dout;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign wr_n      = fr_mode ? (intr_n & ~kick) : wr_drv;
  assign conv_done = fr_mode ? fr_done : man_done;
  assign conv_code = fr_mode ? fr_code : man_code;

  cvt_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .conv_done(conv_done), .conv_code(conv_code),
    .seq_reset(seq_reset), .seq_start(seq_start), .intr_n(intr_n),
    .dout(dout), .dout_oe(dout_oe)
  );

  // Sequencer stand-in for the closed-loop test
  always @(negedge clk) begin
    fr_done <= 1'b0;
    if (fr_mode) begin
      if (seq_start) fr_cnt <= 10;
      else if (fr_cnt > 0) begin
        fr_cnt <= fr_cnt - 1;
        if (fr_cnt == 1) begin
          fr_done <= 1'b1;
          fr_code <= fr_code + 8'd1;
        end
      end
    end
  end

  always @(posedge clk) cycles++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nwait(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Hold the start request for 'w' cycles, then release and check the launch
  task automatic do_start(int w);
    cs_n = 0; wr_drv = 0;
    nwait(2);
    chk("R2 no hold before sync", seq_reset, 0);
    nwait(1);
    chk("R2 hold", seq_reset, 1);
    chk("R3 intr inactive", intr_n, 1);
    nwait(w);
    chk("R2 hold persists", seq_reset, 1);
    wr_drv = 1; cs_n = 1;
    nwait(2);
    chk("R4 still held", seq_reset, 1);
    nwait(1);
    chk("R4 released", seq_reset, 0);
    chk("R4 launch", seq_start, 1);
    nwait(1);
    chk("R4 single launch", seq_start, 0);
  endtask

  task automatic pulse_done(logic [7:0] c);
    man_code = c; man_done = 1;
    nwait(1);
    man_done = 0;
  endtask

  task automatic do_read(int exp_code, string tag);
    cs_n = 0; rd_n = 0;
    nwait(2);
    chk({tag, " oe"}, dout_oe, 1);
    chk({tag, " data"}, dout, exp_code);
    nwait(1);
    chk("R6 intr cleared", intr_n, 1);
    rd_n = 1; cs_n = 1;
    nwait(2);
    chk("R6 oe off", dout_oe, 0);
    chk("R6 bus zero", dout, 0);
  endtask

  initial begin
    nwait(3);
    chk("R1 intr", intr_n, 1);
    chk("R1 oe", dout_oe, 0);
    chk("R1 dout", dout, 0);
    chk("R1 seq_reset", seq_reset, 0);
    chk("R1 seq_start", seq_start, 0);
    rst_n = 1;
    nwait(2);

    // R8: result while idle is ignored
    pulse_done(8'hA5);
    nwait(3);
    chk("R8 intr idle", intr_n, 1);
    do_read(0, "R8");

    // R5/R6 sweep over every code
    for (int c = 0; c < 256; c++) begin
      do_start(1 + (c % 4));
      nwait(2);
      pulse_done(c[7:0]);
      chk("R5 intr not yet", intr_n, 1);
      nwait(1);
      chk("R5 intr low", intr_n, 0);
      do_read(c, "R6");
    end

    // R7: restart during a conversion
    do_start(2);
    nwait(1);
    pulse_done(8'h3C);
    nwait(2);
    do_read(8'h3C, "R7 base");
    do_start(1);
    nwait(2);
    cs_n = 0; wr_drv = 0;
    nwait(3);
    pulse_done(8'hC3);
    nwait(3);
    chk("R7 intr stays high", intr_n, 1);
    wr_drv = 1; cs_n = 1;
    nwait(5);
    chk("R7 intr after abort", intr_n, 1);
    do_read(8'h3C, "R7 latch kept");
    pulse_done(8'h5A);
    nwait(2);
    chk("R7 new run intr", intr_n, 0);
    do_read(8'h5A, "R7 new result");

    // R9: closed loop from interrupt to write strobe
    begin
      int falls = 0, starts = 0;
      logic prev = 1'b1;
      cs_n = 0;
      fr_mode = 1;
      nwait(5);
      chk("R9 no self start", seq_start, 0);
      kick = 1;
      nwait(4);
      kick = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (prev && !intr_n) falls++;
        if (seq_start) starts++;
        prev = intr_n;
      end
      checks++;
      if (falls < 10) begin
        errors++;
        $display("FAIL R9 completions actual=%0d expected>=10", falls);
      end
      checks++;
      if (starts < falls || starts > falls + 1) begin
        errors++;
        $display("FAIL R9 launches actual=%0d expected=%0d", starts, falls);
      end
      fr_mode = 0;
      cs_n = 1;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule